// File: doc/BRIEF.md
# UART Channel Register Core

This block is the register-side control of one UART channel. A processor reaches it through a small byte-wide register port: two mode registers that share one address, a read-only status register, a write-only command register, a data address, and an interrupt status/mask address. The serial engine itself is abstracted. A receive strobe delivers a byte or a break event into a four-entry receive FIFO. A transmit strobe hands a byte out of a one-byte transmit holding register.

The command byte packs three sub-commands into separate fields: receiver control, transmitter control and a miscellaneous action. One write can therefore reset the receiver and re-enable it in the same cycle. The miscellaneous field is applied first and the two direction fields after it.

The interrupt output is the OR of the interrupt status bits that the mask register allows through. Mode register 1 selects whether the receive interrupt follows "data ready" or "FIFO full". A break always injects a zero byte. When the FIFO is full, that byte overwrites the newest entry.

Top module: `uart_regcore`

## Requirements
- R1: After reset both mode registers, interrupt status, interrupt mask and `irq` are 0, both directions are disabled, and status (0x04) reads 0x08 (only bit 3, transmitter empty, set).
- R2: A write to 0x00 stores into the mode register that the pointer selects and then points the pointer at mode register 2. A read of 0x00 returns the selected register. A command whose bits[6:4] equal 1 points the pointer back at mode register 1.
- R3: Command bits[1:0] control the receiver and bits[3:2] control the transmitter: 1 enables, 2 disables, 3 and 0 change nothing. Status bit 2 (transmit ready) equals the transmitter enable.
- R4: A write to 0x0C loads the transmit byte and clears status bit 3. If the transmitter is enabled, `tx_valid` is high for exactly the one cycle after that write edge, with `tx_byte` equal to the byte, and bit 3 is set again. A byte written while the transmitter is disabled is held and sent on the edge that enables the transmitter.
- R5: Command bits[6:4] = 3 disables the transmitter, sets status bit 3 and discards a held byte, so no `tx_valid` pulse follows even after a later enable.
- R6: The receive FIFO holds 4 bytes in arrival order. Reading 0x0C returns the oldest byte and removes it. Reading an empty FIFO returns 0. Status bit 0 means not empty and status bit 1 means full.
- R7: A normal received byte (`rx_break` low) is accepted only while the receiver is enabled and the FIFO is not full. Otherwise it is dropped.
- R8: A break event sets interrupt status bit 2 and pushes a 0x00 byte whether the receiver is enabled or not. If the FIFO is full, the zero replaces the newest entry.
- R9: Command bits[6:4] = 5 clears interrupt status bit 2. Bits[6:4] = 2 disables the receiver and empties the FIFO, clearing status bits 0 and 1.
- R10: Interrupt status (read at 0x14) has bit 0 = transmit ready. Bit 1 = FIFO full when mode register 1 bit 6 is set, otherwise not empty. A write to 0x14 sets the mask, and `irq` = OR of (status AND mask).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a data-address read pops the FIFO) |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the current state |
| rx_valid | input | 1 | Receive event strobe |
| rx_break | input | 1 | Receive event is a break |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | One-cycle pulse: a byte leaves the transmitter |
| tx_byte | output | 8 | Byte being sent |
| irq | output | 1 | Masked interrupt request |

## Verification
Writes, commands, receive events and FIFO pops all take effect at the single clock edge on which they are presented. Status, interrupt status, read data and `irq` therefore show the new state in the low phase straight after that edge. `tx_valid` is registered at the same edge and lasts one cycle. The bench drives on the falling edge and samples at the next falling edge, half a cycle after the edge. It checks `tx_valid` at that point and again one cycle later to confirm that it has dropped. Read data is captured while the read strobe is still high, before the edge that performs the pop.

// File: rtl/uart_regcore_pkg.sv
package uart_regcore_pkg;
  localparam int DW = 8;
  localparam int AW = 5;

  localparam logic [AW-1:0] OFS_MODE = 5'h00;
  localparam logic [AW-1:0] OFS_STAT = 5'h04;
  localparam logic [AW-1:0] OFS_CMD  = 5'h08;
  localparam logic [AW-1:0] OFS_DATA = 5'h0C;
  localparam logic [AW-1:0] OFS_INT  = 5'h14;

  typedef enum logic [2:0] {
    MISC_NONE   = 3'd0,
    MISC_PTR    = 3'd1,
    MISC_RXRST  = 3'd2,
    MISC_TXRST  = 3'd3,
    MISC_ERRCLR = 3'd4,
    MISC_BRKCLR = 3'd5,
    MISC_BRK_A  = 3'd6,
    MISC_BRK_B  = 3'd7
  } misc_cmd_e;

  typedef enum logic [1:0] {
    DIR_KEEP = 2'd0,
    DIR_ON   = 2'd1,
    DIR_OFF  = 2'd2,
    DIR_RSVD = 2'd3
  } dir_cmd_e;

  // New enable for a direction, given its current value and the command field
  function automatic logic dir_next(input logic cur, input logic [1:0] fld);
    case (fld)
      DIR_ON:  return 1'b1;
      DIR_OFF: return 1'b0;
      default: return cur;
    endcase
  endfunction

  // Status byte: {0,0,0,0, tx_empty, tx_ready, rx_full, rx_ready}
  function automatic logic [DW-1:0] pack_status(input logic rdy, input logic full,
                                                input logic txr, input logic txe);
    return {4'b0000, txe, txr, full, rdy};
  endfunction

  // Interrupt status byte: bit0 tx, bit1 rx (source chosen by mode bit), bit2 break
  function automatic logic [DW-1:0] pack_isr(input logic txr, input logic rdy,
                                             input logic full, input logic full_sel,
                                             input logic brk);
    return {5'b00000, brk, (full_sel ? full : rdy), txr};
  endfunction
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          pop,
  input  logic          push,
  input  logic          ovw_ok,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          nonempty,
  output logic          full
);
  logic [DW-1:0] mem   [DEPTH];
  logic [DW-1:0] mem_n [DEPTH];
  logic [CW-1:0] cnt_n;
  logic          pop_ok;

  assign nonempty = (count != '0);
  assign full     = (count == CW'(DEPTH));
  assign head     = nonempty ? mem[0] : '0;
  assign pop_ok   = pop && nonempty;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) mem_n[i] = mem[i];
    cnt_n = count;
    if (pop_ok) begin
      for (int i = 0; i < DEPTH - 1; i++) mem_n[i] = mem[i + 1];
      cnt_n = count - 1'b1;
    end
    if (push) begin
      if (cnt_n < CW'(DEPTH)) begin
        for (int i = 0; i < DEPTH; i++)
          if (CW'(i) == cnt_n) mem_n[i] = din;
        cnt_n = cnt_n + 1'b1;
      end else if (ovw_ok) begin
        mem_n[DEPTH-1] = din;
      end
    end
    if (clr) cnt_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      count <= cnt_n;
      for (int i = 0; i < DEPTH; i++) mem[i] <= mem_n[i];
    end
  end

  // R6
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R6
  fifo_pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && nonempty && !push && !clr) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_byte,
  input  logic          txrst,
  input  logic          cmd_wr,
  input  logic [1:0]    dir_fld,
  output logic          tx_en,
  output logic          tx_empty,
  output logic          tx_valid,
  output logic [DW-1:0] tx_byte
);
  import uart_regcore_pkg::*;

  logic [DW-1:0] hold, hold_n;
  logic          en_n, empty_n, fire;

  always_comb begin
    en_n    = tx_en;
    empty_n = tx_empty;
    hold_n  = hold;
    if (txrst) begin
      en_n    = 1'b0;
      empty_n = 1'b1;
    end
    if (cmd_wr) en_n = dir_next(en_n, dir_fld);
    if (load) begin
      hold_n  = load_byte;
      empty_n = 1'b0;
    end
    fire = en_n && !empty_n;
    if (fire) empty_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en    <= 1'b0;
      tx_empty <= 1'b1;
      hold     <= '0;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_en    <= en_n;
      tx_empty <= empty_n;
      hold     <= hold_n;
      tx_valid <= fire;
      if (fire) tx_byte <= hold_n;
    end
  end

  // R4
  tx_sent_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_empty);
  // R5
  txrst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txrst && !load) |=> !tx_valid);
endmodule

// File: rtl/uart_regcore.sv
module uart_regcore #(
  parameter int RX_DEPTH = 4,
  localparam int DW = uart_regcore_pkg::DW,
  localparam int AW = uart_regcore_pkg::AW,
  localparam int CW = $clog2(RX_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rx_valid,
  input  logic          rx_break,
  input  logic [DW-1:0] rx_byte,
  output logic          tx_valid,
  output logic [DW-1:0] tx_byte,
  output logic          irq
);
  import uart_regcore_pkg::*;

  logic [DW-1:0] mode1, mode2, imask;
  logic          mptr, rx_en, brk_flag;

  // Named events
  logic          wr_mode, wr_cmd, wr_data, wr_int, rd_pop;
  logic          misc_ptr, misc_rxrst, misc_txrst, misc_brkclr;
  logic          brk_evt, norm_push, push_evt;
  misc_cmd_e     misc;

  logic [DW-1:0] head, status_b, isr_b;
  logic [CW-1:0] rx_count;
  logic          rx_rdy, rx_full, tx_en, tx_empty;

  assign wr_mode = bus_wr && (bus_addr == OFS_MODE);
  assign wr_cmd  = bus_wr && (bus_addr == OFS_CMD);
  assign wr_data = bus_wr && (bus_addr == OFS_DATA);
  assign wr_int  = bus_wr && (bus_addr == OFS_INT);
  assign rd_pop  = bus_rd && (bus_addr == OFS_DATA);

  assign misc        = misc_cmd_e'(bus_wdata[6:4]);
  assign misc_ptr    = wr_cmd && (misc == MISC_PTR);
  assign misc_rxrst  = wr_cmd && (misc == MISC_RXRST);
  assign misc_txrst  = wr_cmd && (misc == MISC_TXRST);
  assign misc_brkclr = wr_cmd && (misc == MISC_BRKCLR);

  assign brk_evt   = rx_valid && rx_break;
  assign norm_push = rx_valid && !rx_break && rx_en && !rx_full;
  assign push_evt  = brk_evt || norm_push;

  uart_rx_fifo #(.DEPTH(RX_DEPTH), .DW(DW)) rxq_i (
    .clk(clk), .rst_n(rst_n), .clr(misc_rxrst), .pop(rd_pop),
    .push(push_evt), .ovw_ok(brk_evt),
    .din(brk_evt ? '0 : rx_byte),
    .head(head), .count(rx_count), .nonempty(rx_rdy), .full(rx_full)
  );

  uart_tx_path #(.DW(DW)) txp_i (
    .clk(clk), .rst_n(rst_n), .load(wr_data), .load_byte(bus_wdata),
    .txrst(misc_txrst), .cmd_wr(wr_cmd), .dir_fld(bus_wdata[3:2]),
    .tx_en(tx_en), .tx_empty(tx_empty), .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode1    <= '0;
      mode2    <= '0;
      mptr     <= 1'b0;
      imask    <= '0;
      rx_en    <= 1'b0;
      brk_flag <= 1'b0;
    end else begin
      if (wr_mode) begin
        if (mptr) mode2 <= bus_wdata;
        else      mode1 <= bus_wdata;
        mptr <= 1'b1;
      end else if (misc_ptr) begin
        mptr <= 1'b0;
      end
      if (wr_int) imask <= bus_wdata;
      if (wr_cmd) rx_en <= dir_next(misc_rxrst ? 1'b0 : rx_en, bus_wdata[1:0]);
      if (brk_evt)          brk_flag <= 1'b1;
      else if (misc_brkclr) brk_flag <= 1'b0;
    end
  end

  assign status_b = pack_status(rx_rdy, rx_full, tx_en, tx_empty);
  assign isr_b    = pack_isr(tx_en, rx_rdy, rx_full, mode1[6], brk_flag);
  assign irq      = |(isr_b & imask);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_MODE: bus_rdata = mptr ? mode2 : mode1;
        OFS_STAT: bus_rdata = status_b;
        OFS_DATA: bus_rdata = head;
        OFS_INT:  bus_rdata = isr_b;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R2
  mode_ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> mptr);
  // R8
  brk_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> brk_flag && rx_rdy);
  // R7
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_break && !rx_en && !rd_pop && !wr_cmd) |=> $stable(rx_count));
  // R9
  rx_reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misc_rxrst |=> !rx_rdy);
endmodule

// File: tb/uart_regcore_tb.sv
module uart_regcore_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 0, bus_rd = 0, rx_valid = 0, rx_break = 0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, rx_byte = '0;
  logic [7:0] bus_rdata, tx_byte;
  logic       tx_valid, irq;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  uart_regcore dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_break(rx_break), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FIAL_MARK", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic rx(input logic brk, input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_break = brk; rx_byte = b;
    @(negedge clk); rx_valid = 0; rx_break = 0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input string req, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    rd_chk(5'h04, "R1 status", 8'h08);
    rd_chk(5'h14, "R1 isr", 8'h00);
    rd_chk(5'h00, "R1 mode", 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_mode();
    wr(5'h00, 8'h40);
    wr(5'h00, 8'h13);
    rd_chk(5'h00, "R2 mode2", 8'h13);
    wr(5'h08, 8'h10);
    rd_chk(5'h00, "R2 ptr reset mode1", 8'h40);
    wr(5'h00, 8'h00);
    rd_chk(5'h00, "R2 after write mode2", 8'h13);
  endtask

  task automatic t_tx();
    wr(5'h0C, 8'hA5);
    rd_chk(5'h04, "R4 held clears empty", 8'h00);
    chk("R4 no send disabled", {7'd0, tx_valid}, 8'h00);
    wr(5'h08, 8'h04);
    chk("R4 send on enable", {7'd0, tx_valid}, 8'h01);
    chk("R4 byte on enable", tx_byte, 8'hA5);
    @(negedge clk);
    chk("R4 pulse one cycle", {7'd0, tx_valid}, 8'h00);
    rd_chk(5'h04, "R3 tx ready", 8'h0C);
    wr(5'h0C, 8'h3C);
    chk("R4 send enabled", {7'd0, tx_valid}, 8'h01);
    chk("R4 byte enabled", tx_byte, 8'h3C);
    rd_chk(5'h04, "R4 empty again", 8'h0C);
    wr(5'h08, 8'h08);
    rd_chk(5'h04, "R3 tx disable", 8'h08);
    wr(5'h08, 8'h0C);
    rd_chk(5'h04, "R3 reserved no effect", 8'h08);
  endtask

  task automatic t_txrst();
    wr(5'h0C, 8'h77);
    rd_chk(5'h04, "R5 held", 8'h00);
    wr(5'h08, 8'h30);
    chk("R5 no pulse", {7'd0, tx_valid}, 8'h00);
    rd_chk(5'h04, "R5 empty set", 8'h08);
    wr(5'h08, 8'h04);
    chk("R5 discarded", {7'd0, tx_valid}, 8'h00);
    rd_chk(5'h04, "R5 enabled", 8'h0C);
    wr(5'h08, 8'h08);
  endtask

  task automatic t_fifo();
    rx(0, 8'h11);
    rd_chk(5'h04, "R7 drop disabled", 8'h08);
    wr(5'h08, 8'h01);
    rx(0, 8'h11);
    rd_chk(5'h04, "R6 ready", 8'h09);
    rx(0, 8'h22); rx(0, 8'h33); rx(0, 8'h44);
    rd_chk(5'h04, "R6 full", 8'h0B);
    rx(0, 8'h55);
    rd_chk(5'h0C, "R6 order 1", 8'h11);
    rd_chk(5'h04, "R6 not full", 8'h09);
    rd_chk(5'h0C, "R6 order 2", 8'h22);
    rd_chk(5'h0C, "R6 order 3", 8'h33);
    rd_chk(5'h0C, "R7 full drop keeps 44", 8'h44);
    rd_chk(5'h0C, "R6 empty reads 0", 8'h00);
    rd_chk(5'h04, "R6 empty status", 8'h08);
  endtask

  task automatic t_break();
    rx(0, 8'h01); rx(0, 8'h02); rx(0, 8'h03); rx(0, 8'h04);
    rx(1, 8'hEE);
    rd_chk(5'h14, "R8 isr break", 8'h06);
    rd_chk(5'h04, "R8 still full", 8'h0B);
    rd_chk(5'h0C, "R8 e1", 8'h01);
    rd_chk(5'h0C, "R8 e2", 8'h02);
    rd_chk(5'h0C, "R8 e3", 8'h03);
    rd_chk(5'h0C, "R8 overwritten newest", 8'h00);
    rd_chk(5'h04, "R8 drained", 8'h08);
    wr(5'h08, 8'h50);
    rd_chk(5'h14, "R9 break clear", 8'h00);
    wr(5'h08, 8'h02);
    rx(1, 8'h00);
    rd_chk(5'h04, "R8 break while disabled", 8'h09);
    wr(5'h08, 8'h51);
    wr(5'h08, 8'h20);
    rd_chk(5'h04, "R9 rx reset empties", 8'h08);
    rx(0, 8'h99);
    rd_chk(5'h04, "R9 rx reset disables", 8'h08);
  endtask

  task automatic t_irq();
    wr(5'h08, 8'h10);
    wr(5'h00, 8'h40);
    wr(5'h08, 8'h01);
    wr(5'h14, 8'h02);
    rx(0, 8'hA1);
    rd_chk(5'h14, "R10 full source not ready", 8'h00);
    chk("R10 irq low", {7'd0, irq}, 8'h00);
    rx(0, 8'hA2); rx(0, 8'hA3); rx(0, 8'hA4);
    rd_chk(5'h14, "R10 full source", 8'h02);
    chk("R10 irq full", {7'd0, irq}, 8'h01);
    wr(5'h14, 8'h01);
    chk("R10 masked", {7'd0, irq}, 8'h00);
    wr(5'h08, 8'h04);
    chk("R10 tx irq", {7'd0, irq}, 8'h01);
    rd_chk(5'h14, "R10 isr both", 8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_mode();
    t_tx();
    t_txrst();
    t_fifo();
    t_break();
    t_irq();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule